// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer programmed over a simple byte-addressed write port, with a combinational read port. Firmware loads two preload values, picks a counting range, and chooses what should happen on expiry. It then enables the timer and keeps it alive by writing a reload command. The preload registers and the command byte are guarded: a write to one of them counts only when it comes directly after a fixed two-byte key written to the key offset. A sticky lock bit freezes the enable and the configuration until the next hardware reset.

Counting runs in two stages. The first stage counts down from the first preload value. When it runs out, the block raises a timeout flag, can toggle an output pin, and reloads from the second preload value. If the second stage also runs out, the block issues a one-cycle reset request, and a level output reports whether that reset is warm or cold. The counter width is the preload width plus a shift. In the long range, each preload step is worth 2^SHIFT clocks. In the short range, the preload is loaded unshifted.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, both preload registers read as all ones, the control and lock registers read 0, and `tout_flag`, `tog_pin` and `rst_req` are low.
- R2: A write to 0x00 (preload 1), 0x04 (preload 2) or 0x0D (command) takes effect only when the two writes just before it were byte 0x80 and then byte 0x86, both to offset 0x0C. Otherwise the write is ignored.
- R3: Any write other than the expected next key byte returns the key sequence to its start. One guarded write uses up the unlock, so a second guarded write is ignored.
- R4: The counter loads ((p+1)·2^SHIFT)−1 when control bit 2 is clear and p when it is set, where p is the preload of the current stage. The count is readable at offset 0x14.
- R5: While enabled, the counter decrements once per clock. On the edge after it reaches zero in stage 1, the timeout flag sets (port `tout_flag` and bit 9 of offset 0x0C), `tog_pin` inverts unless control bit 5 is set, and the counter loads from preload 2.
- R6: On the edge after the count reaches zero in stage 2, `rst_req` pulses for one cycle if control bit 4 is set, and counting restarts from preload 1 in stage 1. `rst_warm` follows control bit 3.
- R7: A guarded command write with bit 0 set reloads the counter from preload 1 and returns it to stage 1. With bit 1 set, it clears the timeout flag.
- R8: Bit 1 of the lock register at 0x18 enables counting. While that bit is clear, the counter holds the stage-1 load value.
- R9: Bit 0 of the lock register can only be set. While it is set, writes to the control register and to the enable bit have no effect. Only reset clears it.
- R10: The control register at 0x10 reads back bits 2 to 5 exactly as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data, byte registers use bits 7:0 |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Combinational read data |
| tout_flag | output | 1 | First-stage timeout flag |
| tog_pin | output | 1 | Pin inverted at each first-stage expiry |
| rst_req | output | 1 | One-cycle reset request |
| rst_warm | output | 1 | High when the requested reset is warm |

## Verification
The bench builds the block with an 8-bit preload and a shift of 3. With these values, a long-range load is short enough to predict and read back (preload 5 gives 47), and short-range stages last only a handful of clocks. Both expiry stages, the reset pulse, the warm and cold selection, and the pin behaviour can therefore be checked at exact cycles. The all-ones reset preload at this width makes any write that was wrongly accepted show up clearly in the key-sequence vectors.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

   localparam logic [7:0] OFS_PRE1 = 8'h00;
   localparam logic [7:0] OFS_PRE2 = 8'h04;
   localparam logic [7:0] OFS_KEY  = 8'h0C;
   localparam logic [7:0] OFS_CMD  = 8'h0D;
   localparam logic [7:0] OFS_CTRL = 8'h10;
   localparam logic [7:0] OFS_CNT  = 8'h14;
   localparam logic [7:0] OFS_LOCK = 8'h18;

   localparam logic [7:0] KEY_FIRST  = 8'h80;
   localparam logic [7:0] KEY_SECOND = 8'h86;

   localparam int CMD_RELOAD  = 0;
   localparam int CMD_CLRFLAG = 1;
   localparam int CTL_SHORT   = 2;
   localparam int CTL_WARM    = 3;
   localparam int CTL_RSTEN   = 4;
   localparam int CTL_NOTOG   = 5;
   localparam int LK_LOCK     = 0;
   localparam int LK_EN       = 1;
   localparam int FLAG_RD_BIT = 9;

   typedef enum logic [1:0] {
      KEY_IDLE = 2'd0,
      KEY_HALF = 2'd1,
      KEY_OPEN = 2'd2
   } key_st_e;

   // field order matches the read-back bit order 5..2
   typedef struct packed {
      logic no_tog;
      logic rst_en;
      logic warm;
      logic short_sel;
   } ctl_t;

endpackage

// File: rtl/wdk_unlock.sv
module wdk_unlock
   import wdk_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_byte,
   output logic              prot_ok
);

   key_st_e st;
   logic    at_key, at_guarded, first_ok, second_ok;

   assign at_key     = (wr_addr == ADDR_W'(OFS_KEY));
   assign at_guarded = (wr_addr == ADDR_W'(OFS_PRE1)) ||
                       (wr_addr == ADDR_W'(OFS_PRE2)) ||
                       (wr_addr == ADDR_W'(OFS_CMD));
   assign first_ok   = at_key && (wr_byte == KEY_FIRST);
   assign second_ok  = at_key && (wr_byte == KEY_SECOND);
   assign prot_ok    = wr_en && at_guarded && (st == KEY_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= KEY_IDLE;
      end else if (wr_en) begin
         unique case (st)
            KEY_IDLE: st <= first_ok  ? KEY_HALF : KEY_IDLE;
            KEY_HALF: st <= second_ok ? KEY_OPEN : KEY_IDLE;
            default:  st <= KEY_IDLE;
         endcase
      end
   end

   assert_key_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st == KEY_HALF && !(at_key && wr_byte == KEY_SECOND)) |=> st == KEY_IDLE);

   assert_open_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st == KEY_OPEN) |=> st == KEY_IDLE);

   assert_open_needs_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == KEY_OPEN) |-> $past(st) == KEY_HALF);

endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int              ADDR_W  = 5,
   parameter int              DATA_W  = 32,
   parameter int              PRE_W   = 20,
   parameter logic [PRE_W-1:0] PRE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prot_ok,
   output logic [PRE_W-1:0]  pre1,
   output logic [PRE_W-1:0]  pre2,
   output ctl_t              ctl,
   output logic              en,
   output logic              locked,
   output logic              reload_p,
   output logic              clr_p
);

   logic hit_pre1, hit_pre2, hit_cmd, hit_ctrl, hit_lock;

   assign hit_pre1 = wr_en && (wr_addr == ADDR_W'(OFS_PRE1));
   assign hit_pre2 = wr_en && (wr_addr == ADDR_W'(OFS_PRE2));
   assign hit_cmd  = wr_en && (wr_addr == ADDR_W'(OFS_CMD));
   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
   assign hit_lock = wr_en && (wr_addr == ADDR_W'(OFS_LOCK));

   assign reload_p = prot_ok && hit_cmd && wr_data[CMD_RELOAD];
   assign clr_p    = prot_ok && hit_cmd && wr_data[CMD_CLRFLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre1   <= PRE_RST;
         pre2   <= PRE_RST;
         ctl    <= '0;
         en     <= 1'b0;
         locked <= 1'b0;
      end else begin
         if (prot_ok && hit_pre1) pre1 <= wr_data[PRE_W-1:0];
         if (prot_ok && hit_pre2) pre2 <= wr_data[PRE_W-1:0];
         if (hit_ctrl && !locked) begin
            ctl.short_sel <= wr_data[CTL_SHORT];
            ctl.warm      <= wr_data[CTL_WARM];
            ctl.rst_en    <= wr_data[CTL_RSTEN];
            ctl.no_tog    <= wr_data[CTL_NOTOG];
         end
         if (hit_lock && !locked) begin
            en     <= wr_data[LK_EN];
            locked <= wr_data[LK_LOCK];
         end
      end
   end

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   assert_ctl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(ctl));

   assert_en_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(en));

   assert_pre_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !prot_ok) |=> ($stable(pre1) && $stable(pre2)));

endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
   parameter int PRE_W = 20,
   parameter int SHIFT = 15,
   localparam int CNT_W = PRE_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             short_sel,
   input  logic             no_tog,
   input  logic             rst_en,
   input  logic [PRE_W-1:0] pre1,
   input  logic [PRE_W-1:0] pre2,
   input  logic             reload,
   input  logic             clr_flag,
   output logic [CNT_W-1:0] cnt,
   output logic             tout,
   output logic             pin,
   output logic             rst_req,
   output logic             stage
);

   logic [CNT_W-1:0] ld1, ld2, ld1_long, ld2_long;

   generate
      if (SHIFT > 0) begin : g_shifted
         assign ld1_long = {pre1, {SHIFT{1'b1}}};
         assign ld2_long = {pre2, {SHIFT{1'b1}}};
      end else begin : g_plain
         assign ld1_long = pre1;
         assign ld2_long = pre2;
      end
   endgenerate

   assign ld1 = short_sel ? CNT_W'(pre1) : ld1_long;
   assign ld2 = short_sel ? CNT_W'(pre2) : ld2_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         stage   <= 1'b0;
         tout    <= 1'b0;
         pin     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (clr_flag) tout <= 1'b0;
         if (!en || reload) begin
            cnt   <= ld1;
            stage <= 1'b0;
         end else if (cnt == '0) begin
            if (!stage) begin
               tout  <= 1'b1;
               if (!no_tog) pin <= ~pin;
               cnt   <= ld2;
               stage <= 1'b1;
            end else begin
               rst_req <= rst_en;
               cnt     <= ld1;
               stage   <= 1'b0;
            end
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assert_rst_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_from_stage2_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(stage) && $past(rst_en) && !stage));

   assert_flag_enters_stage2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tout) |-> stage);

   assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !reload && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

   assert_hold_stage1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !stage);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdk_pkg::*;
#(
   parameter int               ADDR_W  = 5,
   parameter int               DATA_W  = 32,
   parameter int               PRE_W   = 20,
   parameter int               SHIFT   = 15,
   parameter logic [PRE_W-1:0] PRE_RST = '1,
   localparam int              CNT_W   = PRE_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              tout_flag,
   output logic              tog_pin,
   output logic              rst_req,
   output logic              rst_warm
);

   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must cover offset 0x18 and stay below 17");
   end
   if (DATA_W < 16 || DATA_W < PRE_W) begin : g_bad_data_w
      $error("DATA_W must be at least 16 and at least PRE_W");
   end
   if (PRE_W < 1 || PRE_W > 32) begin : g_bad_pre_w
      $error("PRE_W must lie in 1..32");
   end
   if (SHIFT < 0 || CNT_W > 64) begin : g_bad_shift
      $error("SHIFT must be non-negative and PRE_W+SHIFT at most 64");
   end

   logic             prot_ok, en, locked, reload_p, clr_p, stage;
   logic [PRE_W-1:0] pre1, pre2;
   ctl_t             ctl;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] cnt_rd;

   wdk_unlock #(.ADDR_W(ADDR_W)) u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_byte (wr_data[7:0]),
      .prot_ok (prot_ok)
   );

   wdk_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PRE_W   (PRE_W),
      .PRE_RST (PRE_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .prot_ok  (prot_ok),
      .pre1     (pre1),
      .pre2     (pre2),
      .ctl      (ctl),
      .en       (en),
      .locked   (locked),
      .reload_p (reload_p),
      .clr_p    (clr_p)
   );

   wdk_count #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .short_sel (ctl.short_sel),
      .no_tog    (ctl.no_tog),
      .rst_en    (ctl.rst_en),
      .pre1      (pre1),
      .pre2      (pre2),
      .reload    (reload_p),
      .clr_flag  (clr_p),
      .cnt       (cnt),
      .tout      (tout_flag),
      .pin       (tog_pin),
      .rst_req   (rst_req),
      .stage     (stage)
   );

   generate
      if (CNT_W > DATA_W) begin : g_cnt_trunc
         assign cnt_rd = cnt[DATA_W-1:0];
      end else begin : g_cnt_ext
         assign cnt_rd = DATA_W'(cnt);
      end
   endgenerate

   assign rst_warm = ctl.warm;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFS_PRE1))      rd_data = DATA_W'(pre1);
      else if (rd_addr == ADDR_W'(OFS_PRE2)) rd_data = DATA_W'(pre2);
      else if (rd_addr == ADDR_W'(OFS_KEY))  rd_data[FLAG_RD_BIT] = tout_flag;
      else if (rd_addr == ADDR_W'(OFS_CTRL)) rd_data = DATA_W'({ctl, 2'b00});
      else if (rd_addr == ADDR_W'(OFS_CNT))  rd_data = cnt_rd;
      else if (rd_addr == ADDR_W'(OFS_LOCK)) rd_data = DATA_W'({en, locked});
   end

   assert_pin_moves_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_pin != $past(tog_pin)) |-> (tout_flag && !$past(ctl.no_tog)));

endmodule

// File: tb/wdog_keyed_tb_top.sv
`timescale 1ns/100ps
module wdog_keyed_tb_top;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;
   localparam int PRE_W  = 8;
   localparam int SHIFT  = 3;
   localparam int NVEC   = 19;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              tout_flag, tog_pin, rst_req, rst_warm;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   wdog_keyed #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PRE_W  (PRE_W),
      .SHIFT  (SHIFT)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .tout_flag (tout_flag),
      .tog_pin   (tog_pin),
      .rst_req   (rst_req),
      .rst_warm  (rst_warm)
   );

   // write addr, write data, read-back addr, expected read value
   localparam logic [73:0] VEC [NVEC] = '{
      {5'h00, 32'h11, 5'h00, 32'hFF},
      {5'h0C, 32'h80, 5'h00, 32'hFF},
      {5'h0C, 32'h86, 5'h00, 32'hFF},
      {5'h00, 32'h22, 5'h00, 32'h22},
      {5'h00, 32'h33, 5'h00, 32'h22},
      {5'h0C, 32'h80, 5'h04, 32'hFF},
      {5'h10, 32'h04, 5'h04, 32'hFF},
      {5'h0C, 32'h86, 5'h04, 32'hFF},
      {5'h04, 32'h44, 5'h04, 32'hFF},
      {5'h0C, 32'h86, 5'h04, 32'hFF},
      {5'h0C, 32'h80, 5'h04, 32'hFF},
      {5'h0C, 32'h86, 5'h04, 32'hFF},
      {5'h04, 32'h55, 5'h04, 32'h55},
      {5'h0C, 32'h80, 5'h00, 32'h22},
      {5'h0C, 32'h80, 5'h00, 32'h22},
      {5'h0C, 32'h86, 5'h00, 32'h22},
      {5'h00, 32'h66, 5'h00, 32'h22},
      {5'h10, 32'h3C, 5'h10, 32'h3C},
      {5'h10, 32'h00, 5'h10, 32'h00}
   };

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic keyed(input logic [4:0] a, input logic [31:0] d);
      wr(5'h0C, 32'h80);
      wr(5'h0C, 32'h86);
      wr(a, d);
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      rd_addr = a; #0.2;
      d = rd_data;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      report();
   end

   initial begin
      logic [31:0] v, a0, b0;
      logic        pin0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(5'h00, v); chk("R1 preload1", v, 32'hFF);
      rd(5'h04, v); chk("R1 preload2", v, 32'hFF);
      rd(5'h10, v); chk("R1 control", v, 32'h0);
      rd(5'h18, v); chk("R1 lock", v, 32'h0);
      chk("R1 flag", {31'b0, tout_flag}, 32'h0);
      chk("R1 pin", {31'b0, tog_pin}, 32'h0);
      chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

      // R2 R3 key sequence vectors, R10 control readback
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][73:69], VEC[i][68:37]);
         rd(VEC[i][36:32], v);
         chk($sformatf("R2 R3 R10 vector %0d", i), v, VEC[i][31:0]);
      end

      // R4 short-range load visible while disabled (R8)
      keyed(5'h00, 32'h05);
      keyed(5'h04, 32'h03);
      wr(5'h10, 32'h14);
      step(1);
      rd(5'h14, v); chk("R4 R8 short load", v, 32'd5);

      // R5 R6 two-stage expiry, cold reset, pin toggles
      wr(5'h18, 32'h02);
      step(5);
      rd(5'h14, v); chk("R5 count at zero", v, 32'd0);
      chk("R5 flag before expiry", {31'b0, tout_flag}, 32'h0);
      step(1);
      chk("R5 flag set", {31'b0, tout_flag}, 32'h1);
      chk("R5 pin toggled", {31'b0, tog_pin}, 32'h1);
      rd(5'h0C, v); chk("R5 flag readback bit 9", v, 32'h200);
      rd(5'h14, v); chk("R5 stage2 load", v, 32'd3);
      step(3);
      chk("R6 no request yet", {31'b0, rst_req}, 32'h0);
      step(1);
      chk("R6 request pulse", {31'b0, rst_req}, 32'h1);
      chk("R6 cold reset", {31'b0, rst_warm}, 32'h0);
      rd(5'h14, v); chk("R6 restart from preload1", v, 32'd5);
      step(1);
      chk("R6 pulse one cycle", {31'b0, rst_req}, 32'h0);

      // R7 clear flag, reload, unguarded command ignored (R2)
      keyed(5'h0D, 32'h02);
      chk("R7 flag cleared", {31'b0, tout_flag}, 32'h0);
      keyed(5'h0D, 32'h01);
      rd(5'h14, v); chk("R7 reload", v, 32'd5);
      step(2);
      rd(5'h14, v); chk("R7 counting after reload", v, 32'd3);
      wr(5'h0D, 32'h01);
      rd(5'h14, v); chk("R2 unguarded reload ignored", v, 32'd2);

      // R8 disable holds the load value
      wr(5'h18, 32'h00);
      step(1);
      rd(5'h14, v); chk("R8 held", v, 32'd5);
      step(3);
      rd(5'h14, v); chk("R8 still held", v, 32'd5);

      // R5 R6 warm reset with pin toggle disabled
      wr(5'h10, 32'h3C);
      keyed(5'h0D, 32'h02);
      chk("R7 flag cleared while idle", {31'b0, tout_flag}, 32'h0);
      pin0 = tog_pin;
      wr(5'h18, 32'h02);
      step(6);
      chk("R5 flag set again", {31'b0, tout_flag}, 32'h1);
      chk("R5 pin held when toggle off", {31'b0, tog_pin}, {31'b0, pin0});
      step(4);
      chk("R6 warm request", {31'b0, rst_req}, 32'h1);
      chk("R6 warm level", {31'b0, rst_warm}, 32'h1);

      // R4 long-range load
      wr(5'h18, 32'h00);
      wr(5'h10, 32'h00);
      step(1);
      rd(5'h14, v); chk("R4 long load", v, 32'd47);

      // R9 lock freezes enable and control
      wr(5'h10, 32'h04);
      wr(5'h18, 32'h03);
      rd(5'h18, v); chk("R9 locked enabled", v, 32'h3);
      wr(5'h18, 32'h00);
      rd(5'h18, v); chk("R9 enable kept", v, 32'h3);
      wr(5'h10, 32'h00);
      rd(5'h10, v); chk("R9 control kept", v, 32'h04);
      rd(5'h14, a0);
      step(1);
      rd(5'h14, b0);
      chk("R9 still counting", {31'b0, a0 != b0}, 32'h1);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      rd(5'h18, v); chk("R9 reset clears lock", v, 32'h0);
      rd(5'h10, v); chk("R1 control after reset", v, 32'h0);

      report();
   end

endmodule